// File: doc/BRIEF.md
# Conversion Command Queue Sequencer

This block walks a list of conversion commands kept in a small command RAM and hands each one to an external converter. Each command word carries a channel number and a pause bit. A trigger starts a scan at address 0. For each command, the block raises a conversion request with the channel number. It waits for the converter to report that the result has been stored, then moves to the next address.

A scan ends in one of two ways. The first is a reserved end-of-queue channel code at the current address. The second is the end of the conversion at the last RAM address. In both cases the block emits a one-cycle completion pulse.

A command with its pause bit set emits a one-cycle pause pulse once its result is stored. The queue then rests in a paused state until the next trigger. The exception is a pause on the last RAM address: there the scan finishes, both pulses fire together, and the status returns to idle. A three-valued status output reports whether the queue is idle, running or paused.

Top module: `cq_seq`

## Requirements
- R1: After reset, status is idle (code 0), the conversion request is low, and both event pulses are low.
- R2: A trigger while idle starts a scan whose first command comes from address 0. A trigger while running (status code 1) has no effect: no extra conversions happen, and the queue stays idle after the scan ends.
- R3: A command word is 7 bits wide: bit 6 is the pause bit and bits 5:0 are the channel. Each command that does not hold the end-of-queue code raises `conv_req_o` with `conv_ch_o` equal to its channel. The request is held until a one-cycle `conv_done_i` pulse, and the address advances by one only after that pulse.
- R4: Channel code 63 at the current address ends the scan without any conversion request. The completion pulse fires and the status becomes idle.
- R5: When the conversion at the last RAM address (15 by default) finishes, `done_evt_o` is high for exactly one cycle, in the cycle after the `conv_done_i` pulse, and the status is idle in that same cycle.
- R6: When a command with its pause bit set finishes at any address other than the last, `pause_evt_o` pulses for one cycle, the status becomes paused (code 2), and no request is raised until a trigger arrives.
- R7: A trigger while paused resumes the scan at the address after the paused command.
- R8: A command with its pause bit set at the last RAM address fires `pause_evt_o` and `done_evt_o` in the same cycle, and the status becomes idle rather than paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| trig_i | input | 1 | Start / resume trigger |
| cmd_addr_o | output | ADDR_W (4) | Command RAM read address |
| cmd_data_i | input | CH_W+1 (7) | Command word read back: {pause, channel} |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_ch_o | output | CH_W (6) | Channel to convert |
| conv_done_i | input | 1 | One-cycle pulse: result stored |
| status_o | output | 2 | 0 idle, 1 running, 2 paused |
| done_evt_o | output | 1 | One-cycle completion pulse |
| pause_evt_o | output | 1 | One-cycle pause pulse |

## Verification
The queue programs vary where the end-of-queue code sits (at address 0, in the middle, or absent) and where the pause bit sits (before the end, on the last executed command, past the end, or on the last RAM address). Together they separate the two ways a scan can end, and they show whether a pause that lies beyond the end of the queue is wrongly honoured. The case with a pause on the last address separates a joint pause-and-complete from a plain pause. Extra triggers sent while a scan is running show that a busy queue is neither restarted nor re-armed.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,
    QS_RUN   = 2'd1,
    QS_HALT  = 2'd2
  } q_stat_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FETCH,
    PH_WAIT,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/cq_decode.sv
module cq_decode #(
  parameter int CH_W = 6
) (
  input  logic [CH_W:0]   word_i,
  output logic            eoq_o,
  output logic            pause_o,
  output logic [CH_W-1:0] ch_o
);
  function automatic logic eoq_code(input logic [CH_W-1:0] ch);
    return &ch;
  endfunction

  assign ch_o    = word_i[CH_W-1:0];
  assign pause_o = word_i[CH_W];
  assign eoq_o   = eoq_code(word_i[CH_W-1:0]);
endmodule

// File: rtl/cq_addr.sv
module cq_addr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_o <= '0;
    else if (clr_i) addr_o <= '0;
    else if (inc_i) addr_o <= step(addr_o);
  end

  assign last_o = (addr_o == TOP);
endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
#(
  parameter int CH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic            eoq_i,
  input  logic            pbit_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            last_i,
  input  logic            done_i,
  output logic            clr_o,
  output logic            inc_o,
  output logic            accept_o,
  output logic            req_o,
  output logic [CH_W-1:0] ch_o,
  output logic [1:0]      status_o,
  output logic            done_evt_o,
  output logic            pause_evt_o
);
  phase_e          ph_q, ph_n;
  logic            pb_q;
  logic [CH_W-1:0] ch_q;
  logic            done_n, pause_n, latch;

  always_comb begin
    ph_n     = ph_q;
    clr_o    = 1'b0;
    inc_o    = 1'b0;
    accept_o = 1'b0;
    done_n   = 1'b0;
    pause_n  = 1'b0;
    latch    = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (trig_i) begin
        clr_o = 1'b1;
        ph_n  = PH_FETCH;
      end
      PH_FETCH: if (eoq_i) begin
        done_n = 1'b1;
        ph_n   = PH_IDLE;
      end else begin
        latch = 1'b1;
        ph_n  = PH_WAIT;
      end
      PH_WAIT: if (done_i) begin
        accept_o = 1'b1;
        pause_n  = pb_q;
        if (last_i) begin
          done_n = 1'b1;
          ph_n   = PH_IDLE;
        end else begin
          inc_o = 1'b1;
          ph_n  = pb_q ? PH_HOLD : PH_FETCH;
        end
      end
      PH_HOLD: if (trig_i) ph_n = PH_FETCH;
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      pb_q        <= 1'b0;
      ch_q        <= '0;
      done_evt_o  <= 1'b0;
      pause_evt_o <= 1'b0;
    end else begin
      ph_q        <= ph_n;
      done_evt_o  <= done_n;
      pause_evt_o <= pause_n;
      if (latch) begin
        pb_q <= pbit_i;
        ch_q <= ch_i;
      end
    end
  end

  assign req_o    = (ph_q == PH_WAIT);
  assign ch_o     = ch_q;
  assign status_o = (ph_q == PH_IDLE) ? QS_IDLE :
                    (ph_q == PH_HOLD) ? QS_HALT : QS_RUN;
endmodule

// File: rtl/cq_seq.sv
module cq_seq #(
  parameter int ADDR_W = 4,
  parameter int CH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic [CH_W:0]     cmd_data_i,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_done_i,
  output logic [1:0]        status_o,
  output logic              done_evt_o,
  output logic              pause_evt_o
);
  // named internal events, visible to the bound checker
  logic            eoq_hit;
  logic            pbit;
  logic [CH_W-1:0] ch_rd;
  logic            last_hit;
  logic            addr_clr;
  logic            addr_inc;
  logic            conv_fire;

  cq_decode #(.CH_W(CH_W)) u_dec (
    .word_i (cmd_data_i),
    .eoq_o  (eoq_hit),
    .pause_o(pbit),
    .ch_o   (ch_rd)
  );

  cq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (addr_clr),
    .inc_i (addr_inc),
    .addr_o(cmd_addr_o),
    .last_o(last_hit)
  );

  cq_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .eoq_i      (eoq_hit),
    .pbit_i     (pbit),
    .ch_i       (ch_rd),
    .last_i     (last_hit),
    .done_i     (conv_done_i),
    .clr_o      (addr_clr),
    .inc_o      (addr_inc),
    .accept_o   (conv_fire),
    .req_o      (conv_req_o),
    .ch_o       (conv_ch_o),
    .status_o   (status_o),
    .done_evt_o (done_evt_o),
    .pause_evt_o(pause_evt_o)
  );
endmodule

// File: rtl/cq_seq_chk.sv
module cq_seq_chk #(
  parameter int ADDR_W = 4,
  parameter int CH_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic              conv_req_o,
  input logic [CH_W-1:0]   conv_ch_o,
  input logic              conv_done_i,
  input logic              conv_fire,
  input logic [1:0]        status_o,
  input logic              done_evt_o,
  input logic              pause_evt_o
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o && !conv_done_i |=> conv_req_o);
  // R4
  no_eoq_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |-> (conv_ch_o != {CH_W{1'b1}}));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o) != 2'd0) && !$past(conv_fire) |-> $stable(cmd_addr_o));
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt_o |-> (status_o == 2'd0));
  // R6
  pause_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_evt_o && !done_evt_o |-> (status_o == 2'd2));
  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'd2) && !trig_i |=> !conv_req_o);
endmodule

bind cq_seq cq_seq_chk #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_i     (trig_i),
  .cmd_addr_o (cmd_addr_o),
  .conv_req_o (conv_req_o),
  .conv_ch_o  (conv_ch_o),
  .conv_done_i(conv_done_i),
  .conv_fire  (conv_fire),
  .status_o   (status_o),
  .done_evt_o (done_evt_o),
  .pause_evt_o(pause_evt_o)
);

// File: tb/cq_seq_test.sv
module cq_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic [3:0] cmd_addr;
  logic [6:0] cmd_data;
  logic       conv_req;
  logic [5:0] conv_ch;
  logic       conv_done = 1'b0;
  logic [1:0] status;
  logic       done_evt, pause_evt;
  logic [6:0] mem [16];
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;
  assign cmd_data = mem[cmd_addr];

  cq_seq uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .cmd_addr_o(cmd_addr),
    .cmd_data_i(cmd_data), .conv_req_o(conv_req), .conv_ch_o(conv_ch),
    .conv_done_i(conv_done), .status_o(status), .done_evt_o(done_evt),
    .pause_evt_o(pause_evt)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {eoq addr[15:11], pause addr[10:6], expected conversions[5:1], expected pause pulse[0]}
  // address 16 means "none"
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    {5'd5,  5'd16, 5'd5,  1'b0},
    {5'd16, 5'd16, 5'd16, 1'b0},
    {5'd6,  5'd2,  5'd6,  1'b1},
    {5'd4,  5'd3,  5'd4,  1'b1},
    {5'd16, 5'd15, 5'd16, 1'b1},
    {5'd0,  5'd16, 5'd0,  1'b0},
    {5'd3,  5'd5,  5'd3,  1'b0}
  };

  task automatic run_scan(input int eoq, input int pp, input int exp_conv,
                          input int exp_pz, input bit poke);
    int nconv = 0, npz = 0, ndone = 0, wt = 0;
    bit fin = 0;
    for (int i = 0; i < 16; i++)
      mem[i] = {1'(i == pp), (i == eoq) ? 6'h3F : 6'(i + 1)};
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    for (int c = 0; c < 400 && !fin; c++) begin
      @(negedge clk);
      conv_done = 1'b0;
      trig = 1'b0;
      if (done_evt) begin
        ndone++;
        fin = 1;
        if (pause_evt) npz++;
        check("R5 idle with completion", status, 0);
        if (pause_evt) check("R8 joint pause at last address", pp, 15);
      end else if (pause_evt) begin
        npz++;
        check("R6 status paused", status, 2);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check("R6 no request while paused", conv_req, 0);
        end
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
      end
      if (conv_req && !fin) begin
        wt++;
        if (poke && wt == 1) trig = 1'b1;
        if (wt == 3) begin
          check("R3 channel order (R2 start at 0, R7 resume)", conv_ch, nconv + 1);
          conv_done = 1'b1;
          nconv++;
          wt = 0;
        end
      end
    end
    conv_done = 1'b0;
    trig = 1'b0;
    check("R3 R4 conversion count", nconv, exp_conv);
    check("R6 R8 pause pulses", npz, exp_pz);
    check("R5 completion pulses", ndone, 1);
    @(negedge clk);
    check("R5 completion is one cycle", done_evt, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 stays idle after scan", status, 0);
      check("R2 no request after scan", conv_req, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 7'h3F;
    repeat (3) @(negedge clk);
    check("R1 status", status, 0);
    check("R1 request", conv_req, 0);
    check("R1 done pulse", done_evt, 0);
    check("R1 pause pulse", pause_evt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", status, 0);

    for (int v = 0; v < NV; v++)
      run_scan(int'(VEC[v][15:11]), int'(VEC[v][10:6]),
               int'(VEC[v][5:1]), int'(VEC[v][0]), 1'b0);

    // R2: triggers while running are ignored
    run_scan(8, 16, 8, 0, 1'b1);
    run_scan(16, 7, 16, 1, 1'b1);

    // R4: end code at start: no request at all, completion still fires
    for (int i = 0; i < 16; i++) mem[i] = 7'h7F;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    check("R4 no request on end code", conv_req, 0);
    @(negedge clk);
    check("R4 completion on end code", done_evt, 1);
    check("R4 no pause on end code", pause_evt, 0);
    check("R4 idle after end code", status, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule